// File: doc/BRIEF.md
# Preloadable Up-Counting Tick Timer

This block is a periodic timer whose 16-bit counter advances by one on every pulse of a tick-enable input. The tick is nominally 160 kHz. When the counter steps past 0xFFFF it reloads from a software-written preload register and raises a pending interrupt flag. The period in ticks is therefore 65536 minus the preload, and the preload for a rate of f Hz is 65536 − 160000/f. For example, a preload of 63936 (0xF9C0) yields 100 Hz.

Software reaches the timer through a small halfword register bus that has byte enables. Index 0 holds the preload. Index 1 returns the live count and ignores writes. Index 2 carries a run-mode byte in its upper half and an interrupt control byte in its lower half. The run mode can zero the counter, freeze it with its value kept, or let it count. The interrupt control byte holds an enable bit, a 3-bit priority level, and a write-one acknowledge bit. That bit reads back as the pending flag. The interrupt request output and the level presented with it are both registered.

Top module: `tick_timer`

## Requirements
- R1: After reset the preload, count, run mode, interrupt enable, level and pending flag are all zero, and `irq_req` is low. A read returns its data on `bus_rdata`, with `bus_rvalid` high, one clock after `bus_rd`.
- R2: With run mode 3 (bits 9:8 of index 2), each clock with `tick` high increments the count by one. Reading index 1 returns the live count.
- R3: Run modes 1 and 2 freeze the count at its present value. Ticks have no effect in these modes.
- R4: Run mode 0 forces the count to zero and keeps it there whatever `tick` does. Mode 0 is the reset value.
- R5: When a tick arrives in run mode with the count at 0xFFFF, the count loads the preload value on that same clock and the pending flag sets. Pending reads as bit 7 of index 2.
- R6: `irq_req` goes high one clock after pending, enable (bit 3 of index 2) and a nonzero level (bits 2:0) all hold. `irq_level` shows the level while `irq_req` is high and reads zero otherwise.
- R7: Writing index 2 with byte enable 0 set and data bit 7 at 1 clears pending, unless an overflow happens on the same clock. In that case pending stays set.
- R8: Starting from the reload value, the next overflow comes after exactly 65536 − preload ticks.
- R9: Writing the preload while the counter runs leaves the current count untouched. The new value is first used at the next overflow.
- R10: A frozen timer keeps its pending flag, and its request, until software acknowledges.
- R11: Each byte of a write lands only where its byte enable is set. Bit 0 selects bits 7:0 and bit 1 selects bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable, one clock per 160 kHz period |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Halfword index: 0 preload, 1 count, 2 mode/irq control |
| bus_be | input | 2 | Byte enables for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Priority level of the active request |

## Verification
The bound checker watches the counter's stepping, freezing, zeroing and wrap-to-preload on every clock. On every clock it also confirms that an acknowledge clears pending, that a request only appears one clock after the gating conditions hold, and that a zero level accompanies any idle request line. Several properties are outside what a per-clock check can see. These include the full 65536-tick first period, the shorter period after reload, a mid-run preload rewrite taking effect only at the next wrap, byte-enable merging, and pending surviving a stop. Only the bench's scenarios, read back through the bus, demonstrate those.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  typedef enum logic [1:0] {
    MODE_ZERO = 2'b00,
    MODE_HOLD = 2'b01,
    MODE_ALT  = 2'b10,
    MODE_RUN  = 2'b11
  } run_mode_e;

  localparam logic [1:0] IDX_PRELOAD = 2'd0;
  localparam logic [1:0] IDX_COUNT   = 2'd1;
  localparam logic [1:0] IDX_CTRL    = 2'd2;

  localparam int LVL_W       = 3;
  localparam int BIT_IRQ_EN  = 3;
  localparam int BIT_PENDING = 7;
  localparam int BIT_MODE_LO = 8;

endpackage

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [1:0]           bus_addr,
  input  logic [CNT_W/8-1:0]   bus_be,
  input  logic [CNT_W-1:0]     bus_wdata,
  input  logic [CNT_W-1:0]     live_cnt,
  input  logic                 pend,
  output logic [CNT_W-1:0]     preload,
  output run_mode_e            mode,
  output logic                 irq_en,
  output logic [LVL_W-1:0]     irq_lvl,
  output logic                 ack,
  output logic [CNT_W-1:0]     bus_rdata,
  output logic                 bus_rvalid
);
  localparam int NBYTES = CNT_W / 8;

  logic wr_pre, wr_ctl;
  logic [CNT_W-1:0] ctl_word;
  logic [CNT_W-1:0] rd_mux;

  assign wr_pre = bus_wr && (bus_addr == IDX_PRELOAD);
  assign wr_ctl = bus_wr && (bus_addr == IDX_CTRL);
  assign ack    = wr_ctl && bus_be[0] && bus_wdata[BIT_PENDING];

  for (genvar b = 0; b < NBYTES; b++) begin : g_pre_byte
    always_ff @(posedge clk) begin
      if (rst) begin
        preload[b*8 +: 8] <= '0;
      end else if (wr_pre && bus_be[b]) begin
        preload[b*8 +: 8] <= bus_wdata[b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= MODE_ZERO;
      irq_en  <= 1'b0;
      irq_lvl <= '0;
    end else if (wr_ctl) begin
      if (bus_be[1]) begin
        mode <= run_mode_e'(bus_wdata[BIT_MODE_LO +: 2]);
      end
      if (bus_be[0]) begin
        irq_en  <= bus_wdata[BIT_IRQ_EN];
        irq_lvl <= bus_wdata[LVL_W-1:0];
      end
    end
  end

  always_comb begin
    ctl_word                    = '0;
    ctl_word[BIT_MODE_LO +: 2]  = mode;
    ctl_word[BIT_PENDING]       = pend;
    ctl_word[BIT_IRQ_EN]        = irq_en;
    ctl_word[LVL_W-1:0]         = irq_lvl;
  end

  always_comb begin
    case (bus_addr)
      IDX_PRELOAD: rd_mux = preload;
      IDX_COUNT:   rd_mux = live_cnt;
      IDX_CTRL:    rd_mux = ctl_word;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        bus_rdata <= rd_mux;
      end
    end
  end

endmodule

// File: rtl/tick_timer_counter.sv
module tick_timer_counter
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  run_mode_e        mode,
  input  logic [CNT_W-1:0] preload,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic step;

  assign step = (mode == MODE_RUN) && tick;
  assign wrap = step && (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else begin
      case (mode)
        MODE_ZERO: cnt <= '0;
        MODE_RUN: begin
          if (wrap) begin
            cnt <= preload;
          end else if (step) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/tick_timer_irq.sv
module tick_timer_irq
  import tick_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wrap,
  input  logic             ack,
  input  logic             irq_en,
  input  logic [LVL_W-1:0] irq_lvl,
  output logic             pend,
  output logic             irq_req,
  output logic [LVL_W-1:0] irq_level
);
  logic fire;

  assign fire = pend && irq_en && (irq_lvl != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
    end else if (wrap) begin
      pend <= 1'b1;
    end else if (ack) begin
      pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req   <= 1'b0;
      irq_level <= '0;
    end else begin
      irq_req   <= fire;
      irq_level <= fire ? irq_lvl : '0;
    end
  end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [1:0]           bus_addr,
  input  logic [CNT_W/8-1:0]   bus_be,
  input  logic [CNT_W-1:0]     bus_wdata,
  output logic [CNT_W-1:0]     bus_rdata,
  output logic                 bus_rvalid,
  output logic                 irq_req,
  output logic [LVL_W-1:0]     irq_level
);
  logic [CNT_W-1:0] preload_q;
  logic [CNT_W-1:0] cnt_q;
  run_mode_e        run_mode;
  logic             irq_en;
  logic [LVL_W-1:0] irq_lvl;
  logic             ack;
  logic             wrap;
  logic             pend_q;

  tick_timer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_be     (bus_be),
    .bus_wdata  (bus_wdata),
    .live_cnt   (cnt_q),
    .pend       (pend_q),
    .preload    (preload_q),
    .mode       (run_mode),
    .irq_en     (irq_en),
    .irq_lvl    (irq_lvl),
    .ack        (ack),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid)
  );

  tick_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .mode    (run_mode),
    .preload (preload_q),
    .cnt     (cnt_q),
    .wrap    (wrap)
  );

  tick_timer_irq u_irq (
    .clk       (clk),
    .rst       (rst),
    .wrap      (wrap),
    .ack       (ack),
    .irq_en    (irq_en),
    .irq_lvl   (irq_lvl),
    .pend      (pend_q),
    .irq_req   (irq_req),
    .irq_level (irq_level)
  );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input run_mode_e        mode,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] preload,
  input logic             pending,
  input logic             ack,
  input logic             irq_en,
  input logic [LVL_W-1:0] irq_lvl,
  input logic             irq_req,
  input logic [LVL_W-1:0] irq_level
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RUN && tick && count != TOP) |=> count == $past(count) + 1'b1);

  assert_freeze_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_HOLD || mode == MODE_ALT) |=> $stable(count));

  assert_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_ZERO) |=> count == '0);

  assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RUN && tick && count == TOP) |=> (count == $past(preload) && pending));

  assert_gate_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> $past(pending && irq_en && irq_lvl != '0));

  assert_idle_level_R6: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> irq_level == '0);

  assert_ack_R7: assert property (@(posedge clk) disable iff (rst)
    (ack && !(mode == MODE_RUN && tick && count == TOP)) |=> !pending);

  assert_keep_R10: assert property (@(posedge clk) disable iff (rst)
    (pending && !ack) |=> pending);

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .mode      (run_mode),
  .count     (cnt_q),
  .preload   (preload_q),
  .pending   (pend_q),
  .ack       (ack),
  .irq_en    (irq_en),
  .irq_lvl   (irq_lvl),
  .irq_req   (irq_req),
  .irq_level (irq_level)
);

// File: tb/test_tick_timer.sv
`timescale 1ns/1ps
module test_tick_timer;
  localparam int CNT_W = 16;

  typedef struct {
    logic [15:0] exp;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;
  logic        irq_req;
  logic [2:0]  irq_level;

  int n_checks = 0;
  int n_errors = 0;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  tick_timer #(.CNT_W(CNT_W)) i_tick_timer (
    .clk(clk), .rst(rst), .tick(tick),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .irq_req(irq_req), .irq_level(irq_level)
  );

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (bus_rvalid) begin
      n_checks++;
      if (sb_q.size() == 0) begin
        n_errors++;
        $display("FAIL %s: unexpected read data %h, expected none", "R1", bus_rdata);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (bus_rdata !== e.exp) begin
          n_errors++;
          $display("FAIL %s: read %h expected %h", e.req, bus_rdata, e.exp);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] e, input string req);
    exp_t it;
    @(negedge clk);
    it.exp = e; it.req = req;
    sb_q.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic chk_irq(input logic er, input logic [2:0] el, input string req);
    n_checks++;
    if (irq_req !== er || irq_level !== el) begin
      n_errors++;
      $display("FAIL %s: irq_req/level %b/%0d expected %b/%0d", req, irq_req, irq_level, er, el);
    end
  endtask

  initial begin
    #(200000 * 8);
    n_errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    rd(2'd0, 16'h0000, "R1");
    rd(2'd1, 16'h0000, "R1");
    rd(2'd2, 16'h0000, "R1");
    chk_irq(1'b0, 3'd0, "R1");

    // R11 byte enables
    wr(2'd0, 2'b11, 16'hFFF0);
    rd(2'd0, 16'hFFF0, "R11");
    wr(2'd0, 2'b10, 16'h1234);
    rd(2'd0, 16'h12F0, "R11");
    wr(2'd0, 2'b01, 16'hABF0);
    rd(2'd0, 16'h12F0, "R11");
    wr(2'd0, 2'b11, 16'hFFF0);
    wr(2'd1, 2'b11, 16'h5555);        // count index ignores writes
    rd(2'd1, 16'h0000, "R11");

    // R2 counting
    wr(2'd2, 2'b10, 16'h0300);
    ticks(10);
    rd(2'd1, 16'd10, "R2");

    // R3 freeze (modes 1 and 2)
    wr(2'd2, 2'b10, 16'h0100);
    ticks(5);
    rd(2'd1, 16'd10, "R3");
    wr(2'd2, 2'b10, 16'h0200);
    ticks(5);
    rd(2'd1, 16'd10, "R3");

    // R4 clear
    wr(2'd2, 2'b10, 16'h0000);
    rd(2'd1, 16'd0, "R4");
    ticks(4);
    rd(2'd1, 16'd0, "R4");

    // R5 first overflow from zero, irq enabled at level 0
    wr(2'd2, 2'b01, 16'h0008);
    wr(2'd2, 2'b10, 16'h0300);
    ticks(65535);
    rd(2'd1, 16'hFFFF, "R5");
    rd(2'd2, 16'h0308, "R5");
    ticks(1);
    rd(2'd1, 16'hFFF0, "R5");
    rd(2'd2, 16'h0388, "R5");
    idle(2);
    chk_irq(1'b0, 3'd0, "R6");

    // R6 nonzero level raises request
    wr(2'd2, 2'b01, 16'h000D);
    idle(2);
    chk_irq(1'b1, 3'd5, "R6");

    // R10 frozen timer keeps pending
    wr(2'd2, 2'b10, 16'h0100);
    ticks(3);
    rd(2'd2, 16'h018D, "R10");
    rd(2'd1, 16'hFFF0, "R10");
    chk_irq(1'b1, 3'd5, "R10");

    // R7 acknowledge
    wr(2'd2, 2'b11, 16'h038D);
    idle(2);
    chk_irq(1'b0, 3'd0, "R7");
    rd(2'd2, 16'h030D, "R7");

    // R8 period = 65536 - 0xFFF0 = 16 ticks
    ticks(15);
    rd(2'd1, 16'hFFFF, "R8");
    rd(2'd2, 16'h030D, "R8");
    ticks(1);
    rd(2'd1, 16'hFFF0, "R8");
    rd(2'd2, 16'h038D, "R8");
    wr(2'd2, 2'b01, 16'h008D);

    // R9 preload rewrite while running
    ticks(3);
    wr(2'd0, 2'b11, 16'hFF00);
    rd(2'd1, 16'hFFF3, "R9");
    ticks(12);
    rd(2'd1, 16'hFFFF, "R9");
    ticks(1);
    rd(2'd1, 16'hFF00, "R9");

    // R6 disabled: no request although pending
    wr(2'd2, 2'b01, 16'h0005);
    idle(2);
    chk_irq(1'b0, 3'd0, "R6");
    rd(2'd2, 16'h0385, "R6");

    idle(3);
    n_checks++;
    if (sb_q.size() != 0) begin
      n_errors++;
      $display("FAIL R1: %0d reads unanswered, expected 0", sb_q.size());
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule